// File: doc/BRIEF.md
# Reset and Calibration Sequencer

This block sequences the start-up of a clock-recovery loop. At system reset it begins a loop-gain calibration at once, with no outside event needed. After that, a control pin that is held high for long enough starts the whole bring-up again. When that pin falls, the loop logic is held cleared for a short fixed time, calibration runs again, and the loop is then released to acquire the incoming data. A calibration engine outside the block receives a one-cycle start pulse and answers with a done pulse. If the answer does not come within a time limit, the block sends the start pulse again.

The block also retimes the recovered data and forces it to binary zero while a squelch input is high. A clock-disable input gates the enable of the recovered-clock driver. All three pins are asynchronous, and each passes through a common synchronizer.

State codes on `seq_state`: 0 power-up calibration, 1 clear (`IDLE`), 2 reset held, 3 calibrate, 4 acquire.

Top module: `rcs_reset_cal_seq`

## Requirements
- R1: While `rst` is high and after it falls, the block is in power-up calibration (code 0). In that state `cal_busy`=1, `acq_en`=0 and `logic_clr`=0, and `cal_start` is 1 in the first cycle after reset.
- R2: While calibrating (code 0 or 3) with no `cal_done`, `cal_start` pulses again every `CAL_TMO_CYC` cycles after the previous pulse, and the state does not change.
- R3: A `cal_done` seen while calibrating moves the state to acquire (code 4, `acq_en`=1) on the next cycle. A `cal_done` in any other state has no effect.
- R4: `rstcal_pin` is sampled after `SYNC_STAGES` synchronizer flops. A high run shorter than `MIN_HOLD_CYC` consecutive samples is ignored.
- R5: Once the synchronized pin has been high for `MIN_HOLD_CYC` samples and is still high, the state becomes reset held (code 2, `logic_clr`=1, `acq_en`=0, `cal_busy`=0). This applies from any other state, and it aborts a calibration or acquisition in progress.
- R6: When a qualified high run ends, the state becomes clear (code 1, `logic_clr`=1) for exactly `CLEAR_CYC` cycles. It then becomes calibrate (code 3), with `cal_start`=1 in its first cycle.
- R7: `dout_p`/`dout_n` carry `rdata`/`~rdata`, registered once. While the synchronized squelch is high, they are 0/1 (binary zero).
- R8: `clk_out_en` is 0 while the synchronized clock-disable is high and 1 otherwise, registered once after the synchronizer.
- R9: Reset clears all synchronizer flops to the deasserted level and sets `dout_p`=0, `dout_n`=1, `clk_out_en`=1. In the first cycle after reset, data passes whatever the squelch pin did before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| rstcal_pin | input | 1 | Asynchronous reset/calibrate request, active high |
| squelch_pin | input | 1 | Asynchronous data squelch, active high |
| clkoff_pin | input | 1 | Asynchronous recovered-clock disable, active high |
| rdata | input | 1 | Recovered data bit |
| cal_done | input | 1 | Calibration finished pulse from the engine |
| cal_start | output | 1 | Calibration start pulse to the engine |
| cal_busy | output | 1 | Calibration in progress |
| logic_clr | output | 1 | Hold loop logic in its initial state |
| acq_en | output | 1 | Loop released to acquire data |
| seq_state | output | 3 | Sequencer state code |
| dout_p | output | 1 | Data output, true side |
| dout_n | output | 1 | Data output, complement side |
| clk_out_en | output | 1 | Recovered-clock driver enable |

## Verification
A wrong state or timer value shows on `seq_state`, `cal_start`, `logic_clr` and `acq_en` no later than the next clock edge. That makes a cycle-by-cycle comparison against a behavioural model decisive. An off-by-one in the pin qualifier shows up as a pulse of exactly `MIN_HOLD_CYC` or `MIN_HOLD_CYC-1` samples being handled wrongly. The clear window and the timeout show up as a `cal_start` pulse one cycle early or late. The data gate is checked for the fixed latency of the synchronizer plus one register.

// File: rtl/rcs_pkg.sv
`timescale 1ns/1ps
package rcs_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP_CAL = 3'd0,
        ST_IDLE        = 3'd1,
        ST_RESET_HELD  = 3'd2,
        ST_CALIBRATE   = 3'd3,
        ST_ACQUIRE     = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic cal_start;
        logic cal_busy;
        logic logic_clr;
        logic acq_en;
    } seq_ctrl_t;

    function automatic logic is_cal_state(input seq_state_e s);
        return (s == ST_POWERUP_CAL) || (s == ST_CALIBRATE);
    endfunction

    function automatic logic is_clear_state(input seq_state_e s);
        return (s == ST_RESET_HELD) || (s == ST_IDLE);
    endfunction

    function automatic seq_ctrl_t decode_ctrl(input seq_state_e s, input logic tmr_zero);
        seq_ctrl_t c;
        c.cal_busy  = is_cal_state(s);
        c.cal_start = is_cal_state(s) && tmr_zero;
        c.logic_clr = is_clear_state(s);
        c.acq_en    = (s == ST_ACQUIRE);
        return c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rcs_sync.sv
`timescale 1ns/1ps
module rcs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rcs_pulse_qual.sv
`timescale 1ns/1ps
module rcs_pulse_qual #(
    parameter int MIN_HOLD_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_s,
    output logic held_q,
    output logic release_q
);
    localparam int CNT_W = $clog2(MIN_HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(MIN_HOLD_CYC);

    logic [CNT_W-1:0] run_cnt;
    logic             run_full;

    always_ff @(posedge clk) begin
        if (rst)            run_cnt <= '0;
        else if (!pin_s)    run_cnt <= '0;
        else if (!run_full) run_cnt <= run_cnt + CNT_W'(1);
    end

    assign run_full  = (run_cnt == FULL);
    assign held_q    = pin_s && run_full;
    assign release_q = !pin_s && run_full;

    a_r4_release_after_high: assert property (@(posedge clk) disable iff (rst)
        release_q |-> $past(pin_s));
    a_r4_held_needs_history: assert property (@(posedge clk) disable iff (rst)
        held_q |-> $past(pin_s));
endmodule

// File: rtl/rcs_seq_fsm.sv
`timescale 1ns/1ps
module rcs_seq_fsm
    import rcs_pkg::*;
#(
    parameter int CAL_TMO_CYC = 1000000,
    parameter int CLEAR_CYC   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       held_q,
    input  logic       release_q,
    input  logic       cal_done,
    output seq_state_e state,
    output seq_ctrl_t  ctrl
);
    localparam int TMR_MAX = max_of(CAL_TMO_CYC, CLEAR_CYC);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] TMO_LAST = TMR_W'(CAL_TMO_CYC - 1);
    localparam logic [TMR_W-1:0] CLR_LAST = TMR_W'(CLEAR_CYC - 1);

    logic [TMR_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_POWERUP_CAL;
            tmr   <= '0;
        end else if (release_q) begin
            state <= ST_IDLE;
            tmr   <= '0;
        end else if (held_q && state != ST_RESET_HELD) begin
            state <= ST_RESET_HELD;
            tmr   <= '0;
        end else begin
            case (state)
                ST_POWERUP_CAL, ST_CALIBRATE: begin
                    if (cal_done) begin
                        state <= ST_ACQUIRE;
                        tmr   <= '0;
                    end else if (tmr == TMO_LAST) begin
                        tmr   <= '0;
                    end else begin
                        tmr   <= tmr + TMR_W'(1);
                    end
                end
                ST_IDLE: begin
                    if (tmr == CLR_LAST) begin
                        state <= ST_CALIBRATE;
                        tmr   <= '0;
                    end else begin
                        tmr   <= tmr + TMR_W'(1);
                    end
                end
                default: tmr <= '0;
            endcase
        end
    end

    always_comb ctrl = decode_ctrl(state, tmr == '0);

    a_r3_done_to_acquire: assert property (@(posedge clk) disable iff (rst)
        (is_cal_state(state) && cal_done && !held_q && !release_q) |=> state == ST_ACQUIRE);
    a_r5_qual_to_held: assert property (@(posedge clk) disable iff (rst)
        (held_q && !release_q) |=> state == ST_RESET_HELD);
    a_r6_release_to_idle: assert property (@(posedge clk) disable iff (rst)
        release_q |=> state == ST_IDLE);
    a_r6_idle_to_cal: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && tmr == CLR_LAST && !release_q && !held_q)
        |=> (state == ST_CALIBRATE && ctrl.cal_start));
    a_r2_window_bound: assert property (@(posedge clk) disable iff (rst)
        is_cal_state(state) |-> tmr <= TMO_LAST);
endmodule

// File: rtl/rcs_out_gate.sv
`timescale 1ns/1ps
module rcs_out_gate (
    input  logic clk,
    input  logic rst,
    input  logic rdata,
    input  logic squelch_s,
    input  logic clkoff_s,
    output logic dout_p,
    output logic dout_n,
    output logic clk_out_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout_p     <= 1'b0;
            dout_n     <= 1'b1;
            clk_out_en <= 1'b1;
        end else begin
            dout_p     <= !squelch_s && rdata;
            dout_n     <= squelch_s || !rdata;
            clk_out_en <= !clkoff_s;
        end
    end

    a_r7_squelch_zero: assert property (@(posedge clk) disable iff (rst)
        squelch_s |=> (!dout_p && dout_n));
    a_r7_pair_opposed: assert property (@(posedge clk) disable iff (rst)
        dout_p != dout_n);
    a_r8_clock_gated: assert property (@(posedge clk) disable iff (rst)
        clkoff_s |=> !clk_out_en);
endmodule

// File: rtl/rcs_reset_cal_seq.sv
`timescale 1ns/1ps
module rcs_reset_cal_seq
    import rcs_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int MIN_HOLD_CYC = 200,
    parameter int CAL_TMO_CYC  = 1000000,
    parameter int CLEAR_CYC    = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rstcal_pin,
    input  logic       squelch_pin,
    input  logic       clkoff_pin,
    input  logic       rdata,
    input  logic       cal_done,
    output logic       cal_start,
    output logic       cal_busy,
    output logic       logic_clr,
    output logic       acq_en,
    output logic [2:0] seq_state,
    output logic       dout_p,
    output logic       dout_n,
    output logic       clk_out_en
);
    localparam int NPINS = 3;

    logic [NPINS-1:0] pins_s;
    logic             held_q, release_q;
    seq_state_e       state;
    seq_ctrl_t        ctrl;

    rcs_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({clkoff_pin, squelch_pin, rstcal_pin}),
        .q   (pins_s)
    );

    rcs_pulse_qual #(.MIN_HOLD_CYC(MIN_HOLD_CYC)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .pin_s     (pins_s[0]),
        .held_q    (held_q),
        .release_q (release_q)
    );

    rcs_seq_fsm #(.CAL_TMO_CYC(CAL_TMO_CYC), .CLEAR_CYC(CLEAR_CYC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .held_q    (held_q),
        .release_q (release_q),
        .cal_done  (cal_done),
        .state     (state),
        .ctrl      (ctrl)
    );

    rcs_out_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .rdata      (rdata),
        .squelch_s  (pins_s[1]),
        .clkoff_s   (pins_s[2]),
        .dout_p     (dout_p),
        .dout_n     (dout_n),
        .clk_out_en (clk_out_en)
    );

    assign seq_state = state;
    assign cal_start = ctrl.cal_start;
    assign cal_busy  = ctrl.cal_busy;
    assign logic_clr = ctrl.logic_clr;
    assign acq_en    = ctrl.acq_en;

    a_r5_clear_blocks_acq: assert property (@(posedge clk) disable iff (rst)
        logic_clr |-> (!acq_en && !cal_busy));
endmodule

// File: tb/tb_rcs_reset_cal_seq.sv
`timescale 1ns/1ps
module tb_rcs_reset_cal_seq;
    localparam int S   = 2;
    localparam int M   = 8;
    localparam int TMO = 20;
    localparam int CLR = 3;

    logic clk = 1'b0;
    logic rst, rstcal_pin, squelch_pin, clkoff_pin, rdata, cal_done;
    logic cal_start, cal_busy, logic_clr, acq_en, dout_p, dout_n, clk_out_en;
    logic [2:0] seq_state;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rcs_reset_cal_seq #(.SYNC_STAGES(S), .MIN_HOLD_CYC(M), .CAL_TMO_CYC(TMO), .CLEAR_CYC(CLR)) dut (
        .clk(clk), .rst(rst), .rstcal_pin(rstcal_pin), .squelch_pin(squelch_pin),
        .clkoff_pin(clkoff_pin), .rdata(rdata), .cal_done(cal_done),
        .cal_start(cal_start), .cal_busy(cal_busy), .logic_clr(logic_clr),
        .acq_en(acq_en), .seq_state(seq_state), .dout_p(dout_p), .dout_n(dout_n),
        .clk_out_en(clk_out_en)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    int m_st = 0, m_tm = 0, m_run = 0;
    bit m_dp = 0, m_dn = 1, m_ce = 1;
    bit ph[$], sh[$], ch[$];

    initial begin
        for (int i = 0; i < S; i++) begin ph.push_back(0); sh.push_back(0); ch.push_back(0); end
    end

    always @(posedge clk) begin
        bit ps, ss, cs, hold, rel;
        ps = ph[S-1]; ss = sh[S-1]; cs = ch[S-1];
        if (rst) begin
            for (int i = 0; i < S; i++) begin ph[i] = 0; sh[i] = 0; ch[i] = 0; end
            m_st = 0; m_tm = 0; m_run = 0; m_dp = 0; m_dn = 1; m_ce = 1;
        end else begin
            hold = ps && (m_run == M);
            rel  = !ps && (m_run == M);
            if (rel) begin m_st = 1; m_tm = 0; end
            else if (hold && m_st != 2) begin m_st = 2; m_tm = 0; end
            else if (m_st == 0 || m_st == 3) begin
                if (cal_done) begin m_st = 4; m_tm = 0; end
                else m_tm = (m_tm == TMO - 1) ? 0 : m_tm + 1;
            end else if (m_st == 1) begin
                if (m_tm == CLR - 1) begin m_st = 3; m_tm = 0; end
                else m_tm++;
            end
            m_run = ps ? ((m_run < M) ? m_run + 1 : M) : 0;
            m_dp = !ss && rdata;
            m_dn = ss || !rdata;
            m_ce = !cs;
            ph.push_front(rstcal_pin); void'(ph.pop_back());
            sh.push_front(squelch_pin); void'(sh.pop_back());
            ch.push_front(clkoff_pin); void'(ch.pop_back());
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3", "seq_state", int'(seq_state), m_st);
            chk("R2", "cal_start", int'(cal_start), int'((m_st == 0 || m_st == 3) && m_tm == 0));
            chk("R1", "cal_busy", int'(cal_busy), int'(m_st == 0 || m_st == 3));
            chk("R6", "logic_clr", int'(logic_clr), int'(m_st == 1 || m_st == 2));
            chk("R3", "acq_en", int'(acq_en), int'(m_st == 4));
            chk("R7", "dout_p", int'(dout_p), int'(m_dp));
            chk("R7", "dout_n", int'(dout_n), int'(m_dn));
            chk("R8", "clk_out_en", int'(clk_out_en), int'(m_ce));
        end
    end

    task automatic wait_state(input int code, input int maxc, input string req);
        int k = 0;
        while (seq_state !== 3'(code) && k < maxc) begin @(negedge clk); k++; end
        chk(req, "reached state", int'(seq_state), code);
    endtask

    task automatic done_pulse();
        cal_done = 1; @(negedge clk); cal_done = 0;
    endtask

    initial begin
        int n;
        rst = 1; rstcal_pin = 0; squelch_pin = 0; clkoff_pin = 0; rdata = 0; cal_done = 0;
        @(posedge clk); cmp_on = 1;
        repeat (3) @(negedge clk);
        chk("R1", "reset state", int'(seq_state), 0);
        chk("R1", "reset cal_start", int'(cal_start), 1);
        chk("R1", "reset acq_en", int'(acq_en), 0);
        chk("R9", "reset dout_n", int'(dout_n), 1);
        chk("R9", "reset clk_out_en", int'(clk_out_en), 1);
        rst = 0;
        // R2: no done, restarts every TMO cycles
        n = 0;
        for (int i = 0; i < 3 * TMO; i++) begin @(negedge clk); if (cal_start) n++; end
        chk("R2", "restart pulses", n, 3);
        chk("R2", "still powerup", int'(seq_state), 0);
        done_pulse();
        chk("R3", "acquire after done", int'(seq_state), 4);
        // R3: done ignored in acquire
        done_pulse();
        repeat (3) @(negedge clk);
        chk("R3", "done ignored", int'(seq_state), 4);
        chk("R3", "no start in acquire", int'(cal_start), 0);
        // R4: short pulse ignored
        rstcal_pin = 1; repeat (M - 1) @(negedge clk); rstcal_pin = 0;
        repeat (15) @(negedge clk);
        chk("R4", "short pulse ignored", int'(seq_state), 4);
        chk("R4", "no clear", int'(logic_clr), 0);
        // R6: exact-length pulse
        rstcal_pin = 1; repeat (M) @(negedge clk); rstcal_pin = 0;
        wait_state(1, 20, "R6");
        chk("R6", "clear asserted", int'(logic_clr), 1);
        n = 1; @(negedge clk);
        while (seq_state == 3'd1 && n < 10) begin n++; @(negedge clk); end
        chk("R6", "clear length", n, CLR);
        chk("R6", "calibrate next", int'(seq_state), 3);
        chk("R6", "start on entry", int'(cal_start), 1);
        repeat (4) @(negedge clk); done_pulse();
        wait_state(4, 5, "R3");
        // R5: long pulse holds
        rstcal_pin = 1; repeat (M + 8) @(negedge clk);
        chk("R5", "held state", int'(seq_state), 2);
        chk("R5", "held clear", int'(logic_clr), 1);
        chk("R5", "held no acq", int'(acq_en), 0);
        repeat (10) @(negedge clk); rstcal_pin = 0;
        wait_state(1, 20, "R6");
        wait_state(3, 20, "R6");
        repeat (5) @(negedge clk);
        // R5: abort during calibration
        rstcal_pin = 1; repeat (M + 6) @(negedge clk);
        chk("R5", "abort calibrate", int'(seq_state), 2);
        chk("R5", "abort not busy", int'(cal_busy), 0);
        rstcal_pin = 0;
        wait_state(3, 30, "R6");
        done_pulse();
        wait_state(4, 5, "R3");
        // R7: squelch with random data
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == 25) begin
                chk("R7", "squelch dout_p", int'(dout_p), 0);
                chk("R7", "squelch dout_n", int'(dout_n), 1);
            end
            rdata = 1'($urandom);
            squelch_pin = (i >= 10 && i < 30);
        end
        // R8: clock disable
        clkoff_pin = 1; repeat (S + 2) @(negedge clk);
        chk("R8", "clock off", int'(clk_out_en), 0);
        clkoff_pin = 0; repeat (S + 2) @(negedge clk);
        chk("R8", "clock on", int'(clk_out_en), 1);
        // R9: reset clears synchronized controls
        squelch_pin = 1; clkoff_pin = 1; repeat (5) @(negedge clk);
        rst = 1; squelch_pin = 0; clkoff_pin = 0;
        @(negedge clk);
        chk("R9", "reset clk_out_en", int'(clk_out_en), 1);
        chk("R1", "reset again powerup", int'(seq_state), 0);
        rst = 0; rdata = 1;
        @(negedge clk);
        chk("R9", "data passes after reset", int'(dout_p), 1);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog run hung actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule